// File: doc/BRIEF.md
# Byte-Lane Packet Buffer Writer

This block stores a packet that arrives one byte at a time into a 16 KB memory that is 64 bits wide. Bytes come with a valid strobe, at most one per clock, and may be separated by any number of idle cycles. For each byte, the block places copies of the byte on all eight 8-bit lanes of a registered write bus. It also drives a one-hot byte-enable, so only one lane of the addressed word is stored. A running byte counter supplies both the lane and the word index.

A start-of-packet pulse clears the counter and captures a word offset. The whole packet then lands in a sub-buffer that begins at that word. The memory is made of eight byte-wide banks, one per lane, and each bank is written only when its own enable bit is set. A second write path takes a full 64-bit word with any byte-enable pattern in one cycle. A separate read port returns any stored word one cycle after its address is presented.

Top module: `lane_pkt_buffer`

## Requirements
- R1: After reset, laneWrValid and laneWrBe are 0, the byte counter is 0 and the held word offset is 0. A byte sent before any start pulse therefore goes to word 0, lane 0.
- R2: A byte accepted at a clock edge (byteValid high) appears on the write bus after that edge: laneWrValid is 1 and laneWrData holds the byte copied into all eight lanes.
- R3: For a stream byte, laneWrBe is one-hot. Bit k is set, selecting lane k (laneWrData bits 8k+7..8k), where k is the byte's position in the packet modulo 8. Positions count from 0 at the start pulse.
- R4: For a stream byte, laneWrAddr equals the held word offset plus the packet position divided by 8.
- R5: Cycles with byteValid low do not advance the counter. When neither write path is active, laneWrValid is 0 after that edge.
- R6: A sopPulse clears the counter and samples sopOffset. A change of sopOffset without a pulse has no effect. A byte given in the same cycle as sopPulse is position 0 at the new offset.
- R7: A stream byte changes only its own lane of the addressed word. The other seven lanes keep their earlier contents.
- R8: With wordWrEn high, wordWrData is written to word wordWrAddr in one cycle, on exactly the lanes whose wordWrBe bits are set. Any pattern is allowed, including all eight bits. The write shows on the write bus after the edge.
- R9: If byteValid and wordWrEn are both high in the same cycle, the stream byte is written and the direct word write is dropped.
- R10: rdData holds the contents of word rdAddr as sampled at the previous clock edge (one cycle of read latency).
- R11: The word address wraps modulo 2048, so a packet placed near the top of the memory continues at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sopPulse | input | 1 | Start of packet: clears the counter, samples the offset |
| sopOffset | input | 11 | Word offset of the packet's sub-buffer |
| byteValid | input | 1 | A stream byte is present this cycle |
| byteData | input | 8 | Stream byte |
| wordWrEn | input | 1 | Direct full-word write request |
| wordWrAddr | input | 11 | Word address for the direct write |
| wordWrData | input | 64 | Data for the direct write |
| wordWrBe | input | 8 | Byte-enable pattern for the direct write |
| rdAddr | input | 11 | Read word address |
| rdData | output | 64 | Read word, one cycle after rdAddr |
| laneWrValid | output | 1 | The write bus carries a write this cycle |
| laneWrAddr | output | 11 | Word address on the write bus |
| laneWrData | output | 64 | Data on the write bus |
| laneWrBe | output | 8 | Byte-enable on the write bus |

## Verification
The stream path is driven with four patterns:
- Back-to-back bytes, which show that lane rotation and word advance follow the counter.
- Bytes with irregular idle gaps, which separate "advance on accepted byte" from "advance every cycle".
- A packet that starts near the top word, which shows the address wrapping.
- A change of the offset input in mid-packet without a start pulse, together with a start pulse that coincides with a byte, which shows that the offset is held and position 0 is used.

Direct word writes with full and sparse enable patterns are read back through the read port. A stream byte is then merged into a prefilled word to show that the other lanes are preserved. A collision cycle shows that the stream byte wins and the dropped word write leaves its target untouched.

// File: rtl/lane_buf_pkg.sv
package lane_buf_pkg;
  localparam int LANES      = 8;
  localparam int BYTE_W     = 8;
  localparam int MEM_BYTES  = 16384;
  localparam int WORD_W     = LANES * BYTE_W;
  localparam int LANE_IDX_W = $clog2(LANES);
  localparam int DEPTH      = MEM_BYTES / LANES;
  localparam int ADDR_W     = $clog2(DEPTH);
  localparam int CNT_W      = ADDR_W + LANE_IDX_W;

  // Strobes from the control to the datapath for one cycle
  typedef struct packed {
    logic                  takeByte;
    logic                  takeWord;
    logic [LANE_IDX_W-1:0] lane;
    logic [ADDR_W-1:0]     addr;
  } wr_strobe_t;
endpackage

// File: rtl/lane_byte_bank.sv
module lane_byte_bank #(
  parameter int DEPTH  = 2048,
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
    rdData <= store[rdAddr];
  end
endmodule

// File: rtl/lane_wr_ctrl.sv
module lane_wr_ctrl
  import lane_buf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sopPulse,
  input  logic [ADDR_W-1:0] sopOffset,
  input  logic              byteValid,
  input  logic              wordWrEn,
  input  logic [ADDR_W-1:0] wordWrAddr,
  output wr_strobe_t        strobe
);
  logic [CNT_W-1:0]  byteCnt;
  logic [ADDR_W-1:0] offReg;
  logic [CNT_W-1:0]  effCnt;
  logic [ADDR_W-1:0] effOff;
  logic [ADDR_W-1:0] wordIdx;

  // A start pulse takes effect for a byte that arrives in the same cycle
  assign effCnt  = sopPulse ? '0 : byteCnt;
  assign effOff  = sopPulse ? sopOffset : offReg;
  assign wordIdx = effCnt[CNT_W-1:LANE_IDX_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
      offReg  <= '0;
    end else begin
      if (sopPulse) offReg <= sopOffset;
      if (byteValid)     byteCnt <= effCnt + 1'b1;
      else if (sopPulse) byteCnt <= '0;
    end
  end

  always_comb begin
    strobe.takeByte = byteValid;
    strobe.takeWord = wordWrEn & ~byteValid;   // stream byte has priority
    strobe.lane     = effCnt[LANE_IDX_W-1:0];
    strobe.addr     = byteValid ? (effOff + wordIdx) : wordWrAddr;
  end
endmodule

// File: rtl/lane_wr_datapath.sv
module lane_wr_datapath
  import lane_buf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wr_strobe_t        strobe,
  input  logic [BYTE_W-1:0] byteData,
  input  logic [WORD_W-1:0] wordWrData,
  input  logic [LANES-1:0]  wordWrBe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic              busValid,
  output logic [ADDR_W-1:0] busAddr,
  output logic [WORD_W-1:0] busData,
  output logic [LANES-1:0]  busBe
);
  logic [LANES-1:0]  laneOneHot;
  logic [WORD_W-1:0] nextData;
  logic [LANES-1:0]  nextBe;

  for (genvar k = 0; k < LANES; k++) begin : g_dec
    assign laneOneHot[k] = (strobe.lane == LANE_IDX_W'(k));
  end

  assign nextData = strobe.takeByte ? {LANES{byteData}} : wordWrData;
  assign nextBe   = strobe.takeByte ? laneOneHot : wordWrBe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busValid <= 1'b0;
      busAddr  <= '0;
      busData  <= '0;
      busBe    <= '0;
    end else begin
      busValid <= strobe.takeByte | strobe.takeWord;
      if (strobe.takeByte | strobe.takeWord) begin
        busAddr <= strobe.addr;
        busData <= nextData;
        busBe   <= nextBe;
      end else begin
        busBe <= '0;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    lane_byte_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(BYTE_W)) bank_i (
      .clk    (clk),
      .wrEn   (busValid & busBe[k]),
      .wrAddr (busAddr),
      .wrData (busData[k*BYTE_W +: BYTE_W]),
      .rdAddr (rdAddr),
      .rdData (rdData[k*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/lane_pkt_buffer.sv
module lane_pkt_buffer
  import lane_buf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sopPulse,
  input  logic [ADDR_W-1:0] sopOffset,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              wordWrEn,
  input  logic [ADDR_W-1:0] wordWrAddr,
  input  logic [WORD_W-1:0] wordWrData,
  input  logic [LANES-1:0]  wordWrBe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic              laneWrValid,
  output logic [ADDR_W-1:0] laneWrAddr,
  output logic [WORD_W-1:0] laneWrData,
  output logic [LANES-1:0]  laneWrBe
);
  wr_strobe_t strobe;

  lane_wr_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sopPulse   (sopPulse),
    .sopOffset  (sopOffset),
    .byteValid  (byteValid),
    .wordWrEn   (wordWrEn),
    .wordWrAddr (wordWrAddr),
    .strobe     (strobe)
  );

  lane_wr_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .byteData   (byteData),
    .wordWrData (wordWrData),
    .wordWrBe   (wordWrBe),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .busValid   (laneWrValid),
    .busAddr    (laneWrAddr),
    .busData    (laneWrData),
    .busBe      (laneWrBe)
  );
endmodule

// File: rtl/lane_pkt_buffer_chk.sv
module lane_pkt_buffer_chk
  import lane_buf_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              byteValid,
  input logic [BYTE_W-1:0] byteData,
  input logic              wordWrEn,
  input logic [WORD_W-1:0] wordWrData,
  input logic [LANES-1:0]  wordWrBe,
  input logic              laneWrValid,
  input logic [WORD_W-1:0] laneWrData,
  input logic [LANES-1:0]  laneWrBe
);
  logic              pastByte;
  logic              pastWord;
  logic [BYTE_W-1:0] pastData;
  logic [WORD_W-1:0] pastWordData;
  logic [LANES-1:0]  pastWordBe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pastByte     <= 1'b0;
      pastWord     <= 1'b0;
      pastData     <= '0;
      pastWordData <= '0;
      pastWordBe   <= '0;
    end else begin
      pastByte     <= byteValid;
      pastWord     <= wordWrEn;
      pastData     <= byteData;
      pastWordData <= wordWrData;
      pastWordBe   <= wordWrBe;
    end
  end

  assert_byte_shown_R2: assert property (@(posedge clk) disable iff (!rstN)
    pastByte |-> (laneWrValid && laneWrData == {LANES{pastData}}));

  assert_be_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    pastByte |-> $countones(laneWrBe) == 1);

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!pastByte && !pastWord) |-> (!laneWrValid && laneWrBe == '0));

  assert_word_pattern_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pastWord && !pastByte) |-> (laneWrValid && laneWrBe == pastWordBe
                                 && laneWrData == pastWordData));
endmodule

bind lane_pkt_buffer lane_pkt_buffer_chk chk_i (.*);

// File: tb/lane_pkt_buffer_tb_top.sv
`timescale 1ns/1ps
module lane_pkt_buffer_tb_top;
  localparam int DEPTH = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sopPulse = 1'b0;
  logic [10:0] sopOffset = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        wordWrEn = 1'b0;
  logic [10:0] wordWrAddr = '0;
  logic [63:0] wordWrData = '0;
  logic [7:0]  wordWrBe = '0;
  logic [10:0] rdAddr = '0;
  logic [63:0] rdData;
  logic        laneWrValid;
  logic [10:0] laneWrAddr;
  logic [63:0] laneWrData;
  logic [7:0]  laneWrBe;

  always #2 clk = ~clk;   // 250 MHz

  lane_pkt_buffer dut_i (.*);

  typedef struct {
    logic [10:0] addr;
    logic [63:0] data;
    logic [7:0]  be;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  logic [63:0] model [DEPTH];
  int          nChecks = 0;
  int          nFails  = 0;
  int          pos = 0;
  int          off = 0;
  bit          done = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: pops one expected write for every write seen on the bus
  always @(negedge clk) begin
    exp_t item;
    if (rstN && laneWrValid && !done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected write", {53'd0, laneWrAddr}, 64'd0);
      end else begin
        item = expQ.pop_front();
        check(laneWrAddr === item.addr, {item.tag, " addr"}, {53'd0, laneWrAddr}, {53'd0, item.addr});
        check(laneWrData === item.data, {item.tag, " data"}, laneWrData, item.data);
        check(laneWrBe === item.be, {item.tag, " be"}, {56'd0, laneWrBe}, {56'd0, item.be});
      end
    end
  end

  function automatic exp_t byteExp(input logic [7:0] b, input string tag);
    exp_t e;
    e.addr = 11'((off + pos / 8) % DEPTH);
    e.data = {8{b}};
    e.be   = 8'(1 << (pos % 8));
    e.tag  = tag;
    return e;
  endfunction

  task automatic stampByte(input logic [7:0] b, input string tag);
    exp_t e;
    e = byteExp(b, tag);
    expQ.push_back(e);
    model[e.addr][8*(pos%8) +: 8] = b;
    pos++;
  endtask

  task automatic sendByte(input logic [7:0] b, input string tag);
    byteValid = 1'b1;
    byteData  = b;
    stampByte(b, tag);
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic startPkt(input int o);
    sopPulse  = 1'b1;
    sopOffset = 11'(o);
    pos = 0;
    off = o;
    @(negedge clk);
    sopPulse = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wordWrite(input int a, input logic [63:0] d, input logic [7:0] be);
    exp_t e;
    wordWrEn   = 1'b1;
    wordWrAddr = 11'(a);
    wordWrData = d;
    wordWrBe   = be;
    e.addr = 11'(a);
    e.data = d;
    e.be   = be;
    e.tag  = "R8 word write";
    expQ.push_back(e);
    for (int k = 0; k < 8; k++) if (be[k]) model[a][8*k +: 8] = d[8*k +: 8];
    @(negedge clk);
    wordWrEn = 1'b0;
  endtask

  task automatic readCheck(input int a, input string tag);
    rdAddr = 11'(a);
    @(negedge clk);
    check(rdData === model[a], tag, rdData, model[a]);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    check(laneWrValid === 1'b0, "R1 reset valid", {63'd0, laneWrValid}, 64'd0);
    check(laneWrBe === 8'd0, "R1 reset be", {56'd0, laneWrBe}, 64'd0);

    // R1: no start pulse yet, word 0 lane 0
    pos = 0; off = 0;
    sendByte(8'hA5, "R1 first byte");
    idle(1);

    // R2 R3 R4: back-to-back bytes
    startPkt(100);
    for (int i = 0; i < 12; i++) sendByte(8'(8'h10 + i), "R3 back to back");
    idle(1);
    check(laneWrValid === 1'b0, "R5 bus idle", {63'd0, laneWrValid}, 64'd0);

    // R5: irregular gaps
    startPkt(300);
    for (int i = 0; i < 10; i++) begin
      sendByte(8'(8'h40 + i), "R5 gapped");
      idle(i % 4);
    end
    idle(2);

    // R6: offset change without pulse is ignored; pulse with byte
    startPkt(500);
    for (int i = 0; i < 3; i++) sendByte(8'(8'h60 + i), "R6 held offset");
    sopOffset = 11'd900;
    for (int i = 0; i < 6; i++) sendByte(8'(8'h70 + i), "R6 offset ignored");
    sopPulse = 1'b1; sopOffset = 11'd700; pos = 0; off = 700;
    sendByte(8'h7E, "R6 same-cycle start");
    sopPulse = 1'b0;
    sendByte(8'h7F, "R6 after start");
    idle(2);

    // R11: wrap near the top of memory
    startPkt(2047);
    for (int i = 0; i < 16; i++) sendByte(8'(8'h90 + i), "R11 wrap");
    idle(2);

    // R8 R10: direct word writes and readback
    wordWrite(1200, 64'hFFEE_DDCC_BBAA_9988, 8'hFF);
    wordWrite(1201, 64'h1122_3344_5566_7788, 8'hFF);
    wordWrite(1201, 64'hDEAD_BEEF_CAFE_F00D, 8'h5A);
    idle(2);
    readCheck(1200, "R10 read full word");
    readCheck(1201, "R8 sparse enable");
    readCheck(1200, "R10 read again");

    // R7: stream bytes merge into a prefilled word
    startPkt(1200);
    for (int i = 0; i < 3; i++) sendByte(8'(8'hC0 + i), "R7 merge");
    idle(2);
    readCheck(1200, "R7 other lanes kept");

    // R9: collision, stream byte wins
    wordWrite(1500, 64'h0123_4567_89AB_CDEF, 8'hFF);
    idle(2);
    byteValid = 1'b1; byteData = 8'hC3;
    wordWrEn = 1'b1; wordWrAddr = 11'd1500; wordWrData = 64'd0; wordWrBe = 8'hFF;
    stampByte(8'hC3, "R9 collision byte");
    @(negedge clk);
    byteValid = 1'b0; wordWrEn = 1'b0;
    idle(2);
    readCheck(1500, "R9 dropped word write");
    readCheck(1200, "R9 byte landed");

    idle(3);
    check(expQ.size() == 0, "R2 all writes seen", 64'(expQ.size()), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule